// File: doc/BRIEF.md
# Store-Carried Compute Instruction Decoder

This block sits between a host processor and a compute-capable SRAM macro. The host reaches it over an ordinary SRAM bus with a 32-bit address, 32-bit write data, 32-bit read data, a valid strobe and a read/write select. Each transfer is either a normal memory access or a compute instruction. Normal accesses go to a local storage array. Compute instructions carry no data. Their operands are packed into the address and data words of a store.

The top bit of the address word marks a transfer as a compute instruction. For such a write, the decoder splits the data word into an opcode, two 12-bit operand fields and a select-pattern bit. It takes the 12-bit destination row from the low address bits. It then presents all of these fields to the compute array with a single-cycle issue pulse. It stays busy, and holds off the bus with a wait signal, until the array reports completion. Because normal and compute transfers share one bus, the host can interleave them freely.

Opcodes fall into two classes. In the two-operand class, the operand fields are source row numbers. In the multi-operand class, they are a pattern address and a pattern mask. Malformed requests raise an error flag that stays set until reset and do not issue.

Top module: `smart_bus_decoder`

## Requirements
- R1: After reset, busWait, computeBusy, issueValid and errFlag are 0 and busRdata is 0.
- R2: A transfer with busAddr[31]=0 is a plain access. A write stores busWdata at row busAddr[ROW_BITS-1:0]. A read puts that row's word on busRdata in the cycle after the read is accepted, and busRdata keeps that value until the next accepted read.
- R3: A legal compute write (busAddr[31]=1) puts its fields on the issue outputs in the cycle after acceptance, with issueValid high for exactly that one cycle. The fields are: issueOpcode=busWdata[31:25], issueSrcA=busWdata[24:13], issueSrcB=busWdata[12:1], issuePattern=busWdata[0] and issueDest=busAddr[11:0].
- R4: Opcodes 0x10 to 0x1F form the two-operand class and opcodes 0x20 to 0x2F form the multi-operand class.
- R5: A two-operand opcode with busWdata[0]=1 does not issue and sets errFlag.
- R6: Any opcode outside both classes does not issue and sets errFlag.
- R7: A multi-operand opcode issues whether busWdata[0] is 0 or 1.
- R8: computeBusy rises in the same cycle as issueValid. It stays high until computeDone is sampled high at a clock edge, and is low in the cycle after that edge.
- R9: busWait equals computeBusy. A transfer presented while busWait is high is not accepted: it neither writes the array nor issues.
- R10: A read with busAddr[31]=1 returns 0 on busRdata in the following cycle and sets errFlag.
- R11: Once set, errFlag stays high through later legal traffic until reset.
- R12: A compute write does not modify the storage array, including the row whose number equals its destination field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Transfer request |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 32 | Address word; bit 31 is the compute flag |
| busWdata | input | 32 | Write data or packed instruction |
| busRdata | output | 32 | Read data, registered |
| busWait | output | 1 | Stall: transfers not accepted while high |
| issueValid | output | 1 | One-cycle instruction issue pulse |
| issueOpcode | output | 7 | Decoded opcode |
| issueSrcA | output | 12 | First operand field (source row or pattern address) |
| issueSrcB | output | 12 | Second operand field (source row or pattern mask) |
| issuePattern | output | 1 | Select-pattern bit |
| issueDest | output | 12 | Destination row |
| computeDone | input | 1 | Compute array completion |
| computeBusy | output | 1 | Instruction in flight |
| errFlag | output | 1 | Sticky error |

## Verification
The assertions check four properties on every cycle:
- the issue pulse lasts one cycle;
- no instruction issues out of a busy state;
- busy holds until done and then clears;
- the error flag stays set, and an illegal flagged read returns zero.

Some behaviour can only be shown by the bench's scenarios:
- the exact placement of the decoded fields;
- the opcode class boundaries;
- the rejection of two-operand requests that set the pattern bit;
- the fact that stalled transfers and compute writes leave the storage array unchanged.

The bench shows these by reading the array back and watching the issue outputs.

// File: rtl/smi_pkg.sv
package smi_pkg;
  localparam int OPC_W   = 7;
  localparam int FIELD_W = 12;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_TWO   = 2'd1,
    CLS_MULTI = 2'd2
  } opClass_e;

  typedef struct packed {
    logic memWr;
    logic memRd;
    logic rdZero;
    logic issueLoad;
  } ctrlStrobes_t;

  function automatic opClass_e classifyOp(input logic [OPC_W-1:0] op);
    case (op[6:4])
      3'b001:  classifyOp = CLS_TWO;
      3'b010:  classifyOp = CLS_MULTI;
      default: classifyOp = CLS_NONE;
    endcase
  endfunction
endpackage

// File: rtl/smi_ctrl.sv
module smi_ctrl
  import smi_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               busValid,
  input  logic               busWrite,
  input  logic               smartFlag,
  input  logic [OPC_W-1:0]   opcode,
  input  logic               patBit,
  input  logic               computeDone,
  output ctrlStrobes_t       strobes,
  output logic               issueValid,
  output logic               busyQ,
  output logic               errQ
);
  logic     accepted;
  logic     goodIssue;
  logic     badReq;
  opClass_e opClass;

  always_comb begin
    opClass   = classifyOp(opcode);
    accepted  = busValid && !busyQ;
    goodIssue = accepted && busWrite && smartFlag &&
                ((opClass == CLS_MULTI) || ((opClass == CLS_TWO) && !patBit));
    badReq    = accepted && smartFlag &&
                (!busWrite || (opClass == CLS_NONE) || ((opClass == CLS_TWO) && patBit));
    strobes.memWr     = accepted && busWrite && !smartFlag;
    strobes.memRd     = accepted && !busWrite && !smartFlag;
    strobes.rdZero    = accepted && !busWrite && smartFlag;
    strobes.issueLoad = goodIssue;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueValid <= 1'b0;
      busyQ      <= 1'b0;
      errQ       <= 1'b0;
    end else begin
      issueValid <= goodIssue;
      if (goodIssue)                busyQ <= 1'b1;
      else if (busyQ && computeDone) busyQ <= 1'b0;
      if (badReq) errQ <= 1'b1;
    end
  end

  // R3
  issue_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |=> !issueValid);
  // R9
  no_issue_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> !$past(busyQ));
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && !computeDone) |=> busyQ);
  // R8
  busy_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && computeDone) |=> !busyQ);
  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errQ |=> errQ);
endmodule

// File: rtl/smi_datapath.sv
module smi_datapath
  import smi_pkg::*;
#(
  parameter int ROWS   = 256,
  parameter int DATA_W = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobes,
  input  logic [FIELD_W-1:0]      addrLow,
  input  logic [DATA_W-1:0]       busWdata,
  output logic [DATA_W-1:0]       busRdata,
  output logic [OPC_W-1:0]        issueOpcode,
  output logic [FIELD_W-1:0]      issueSrcA,
  output logic [FIELD_W-1:0]      issueSrcB,
  output logic                    issuePattern,
  output logic [FIELD_W-1:0]      issueDest
);
  localparam int ROW_BITS = $clog2(ROWS);
  localparam int OPC_LSB  = DATA_W - OPC_W;
  localparam int SRCA_LSB = OPC_LSB - FIELD_W;
  localparam int SRCB_LSB = SRCA_LSB - FIELD_W;

  logic [DATA_W-1:0]   store [ROWS];
  logic [ROW_BITS-1:0] rowIdx;

  assign rowIdx = addrLow[ROW_BITS-1:0];

  always_ff @(posedge clk) begin
    if (strobes.memWr) store[rowIdx] <= busWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               busRdata <= '0;
    else if (strobes.memRd)  busRdata <= store[rowIdx];
    else if (strobes.rdZero) busRdata <= '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      issueOpcode  <= '0;
      issueSrcA    <= '0;
      issueSrcB    <= '0;
      issuePattern <= 1'b0;
      issueDest    <= '0;
    end else if (strobes.issueLoad) begin
      issueOpcode  <= busWdata[DATA_W-1:OPC_LSB];
      issueSrcA    <= busWdata[OPC_LSB-1:SRCA_LSB];
      issueSrcB    <= busWdata[SRCA_LSB-1:SRCB_LSB];
      issuePattern <= busWdata[0];
      issueDest    <= addrLow;
    end
  end

  // R10
  illegal_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdZero |=> (busRdata == '0));
endmodule

// File: rtl/smart_bus_decoder.sv
module smart_bus_decoder
  import smi_pkg::*;
#(
  parameter int ROWS = 256
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic [31:0]         busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  output logic                busWait,
  output logic                issueValid,
  output logic [OPC_W-1:0]    issueOpcode,
  output logic [FIELD_W-1:0]  issueSrcA,
  output logic [FIELD_W-1:0]  issueSrcB,
  output logic                issuePattern,
  output logic [FIELD_W-1:0]  issueDest,
  input  logic                computeDone,
  output logic                computeBusy,
  output logic                errFlag
);
  ctrlStrobes_t strobes;
  logic         busyQ;

  smi_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .busValid    (busValid),
    .busWrite    (busWrite),
    .smartFlag   (busAddr[31]),
    .opcode      (busWdata[31:25]),
    .patBit      (busWdata[0]),
    .computeDone (computeDone),
    .strobes     (strobes),
    .issueValid  (issueValid),
    .busyQ       (busyQ),
    .errQ        (errFlag)
  );

  smi_datapath #(.ROWS(ROWS), .DATA_W(32)) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .addrLow      (busAddr[FIELD_W-1:0]),
    .busWdata     (busWdata),
    .busRdata     (busRdata),
    .issueOpcode  (issueOpcode),
    .issueSrcA    (issueSrcA),
    .issueSrcB    (issueSrcB),
    .issuePattern (issuePattern),
    .issueDest    (issueDest)
  );

  assign busWait     = busyQ;
  assign computeBusy = busyQ;
endmodule

// File: tb/sim_smart_bus_decoder.sv
module sim_smart_bus_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0, computeDone = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [31:0] busRdata;
  logic        busWait, issueValid, issuePattern, computeBusy, errFlag;
  logic [6:0]  issueOpcode;
  logic [11:0] issueSrcA, issueSrcB, issueDest;

  int compared = 0, mismatched = 0, cycles = 0;

  always #2.5 clk = ~clk;

  smart_bus_decoder u0 (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack(input logic [6:0] op, input logic [11:0] a,
                                       input logic [11:0] b, input logic p);
    return {op, a, b, p};
  endfunction

  // one transfer held for one edge; returns at the following negedge
  task automatic xfer(input logic wr, input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = addr; busWdata = data;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic finishCompute(input string req);
    @(negedge clk); computeDone = 1'b1;
    @(negedge clk); computeDone = 1'b0;
    check(req, {31'd0, computeBusy}, 32'd0);
    check(req, {31'd0, busWait}, 32'd0);
  endtask

  task automatic t_reset();
    check("R1 wait", {31'd0, busWait}, 0);
    check("R1 busy", {31'd0, computeBusy}, 0);
    check("R1 issue", {31'd0, issueValid}, 0);
    check("R1 err", {31'd0, errFlag}, 0);
    check("R1 rdata", busRdata, 0);
  endtask

  task automatic t_plain();
    xfer(1, 32'h0000_0005, 32'hA5A5_1234);
    xfer(1, 32'h0000_00FF, 32'h0F0F_F0F0);
    xfer(0, 32'h0000_0005, 0);
    check("R2 read row5", busRdata, 32'hA5A5_1234);
    xfer(0, 32'h0000_00FF, 0);
    check("R2 read row255", busRdata, 32'h0F0F_F0F0);
    @(negedge clk);
    check("R2 rdata held", busRdata, 32'h0F0F_F0F0);
  endtask

  task automatic t_twoop();
    xfer(1, 32'h8000_0005, pack(7'h13, 12'h123, 12'hABC, 1'b0));
    check("R3 R4 issue pulse", {31'd0, issueValid}, 1);
    check("R3 opcode", {25'd0, issueOpcode}, 32'h13);
    check("R3 srcA", {20'd0, issueSrcA}, 32'h123);
    check("R3 srcB", {20'd0, issueSrcB}, 32'hABC);
    check("R3 pattern", {31'd0, issuePattern}, 0);
    check("R3 dest", {20'd0, issueDest}, 32'h005);
    check("R8 busy rises", {31'd0, computeBusy}, 1);
    check("R9 wait", {31'd0, busWait}, 1);
    @(negedge clk);
    check("R3 single pulse", {31'd0, issueValid}, 0);
    check("R8 busy held", {31'd0, computeBusy}, 1);
    // R9: stalled plain write and compute write must be ignored
    busValid = 1; busWrite = 1; busAddr = 32'h0000_0005; busWdata = 32'hDEAD_BEEF;
    @(negedge clk);
    check("R9 no issue while busy", {31'd0, issueValid}, 0);
    busAddr = 32'h8000_0010; busWdata = pack(7'h21, 12'h1, 12'h2, 1'b1);
    @(negedge clk);
    check("R9 no issue while busy", {31'd0, issueValid}, 0);
    busValid = 0; busWrite = 0;
    finishCompute("R8 clears after done");
    xfer(0, 32'h0000_0005, 0);
    check("R9 R12 row5 unchanged", busRdata, 32'hA5A5_1234);
  endtask

  task automatic t_multi();
    xfer(1, 32'h8000_0FFF, pack(7'h25, 12'hF0F, 12'h00C, 1'b1));
    check("R7 multi pat1 issues", {31'd0, issueValid}, 1);
    check("R7 pattern bit", {31'd0, issuePattern}, 1);
    check("R7 dest", {20'd0, issueDest}, 32'hFFF);
    finishCompute("R8 clears");
    xfer(1, 32'h8000_0001, pack(7'h2F, 12'h3, 12'h4, 1'b0));
    check("R7 R4 multi pat0 issues", {31'd0, issueValid}, 1);
    finishCompute("R8 clears");
    xfer(1, 32'h8000_0002, pack(7'h1F, 12'h7, 12'h8, 1'b0));
    check("R4 0x1F two-op issues", {31'd0, issueValid}, 1);
    finishCompute("R8 clears");
    check("R4 no error", {31'd0, errFlag}, 0);
  endtask

  task automatic t_badpat();
    doReset();
    xfer(1, 32'h8000_0003, pack(7'h10, 12'h5, 12'h6, 1'b1));
    check("R5 no issue", {31'd0, issueValid}, 0);
    check("R5 no busy", {31'd0, computeBusy}, 0);
    check("R5 err", {31'd0, errFlag}, 1);
    xfer(1, 32'h0000_0001, 32'h1111_2222);
    xfer(0, 32'h0000_0001, 0);
    check("R11 err sticky", {31'd0, errFlag}, 1);
    check("R2 after error", busRdata, 32'h1111_2222);
  endtask

  task automatic t_unknown();
    doReset();
    check("R1 err cleared", {31'd0, errFlag}, 0);
    xfer(1, 32'h8000_0003, pack(7'h30, 12'h5, 12'h6, 1'b0));
    check("R6 no issue 0x30", {31'd0, issueValid}, 0);
    check("R6 err", {31'd0, errFlag}, 1);
    doReset();
    xfer(1, 32'h8000_0003, pack(7'h0F, 12'h5, 12'h6, 1'b0));
    check("R6 no issue 0x0F", {31'd0, issueValid}, 0);
    check("R6 err", {31'd0, errFlag}, 1);
  endtask

  task automatic t_illread();
    doReset();
    xfer(1, 32'h0000_0003, 32'hCAFE_F00D);
    xfer(0, 32'h0000_0003, 0);
    check("R2 row3", busRdata, 32'hCAFE_F00D);
    xfer(0, 32'h8000_0003, 0);
    check("R10 zero data", busRdata, 0);
    check("R10 err", {31'd0, errFlag}, 1);
    // R12: compute write aimed at row 3 leaves it alone
    xfer(1, 32'h8000_0003, pack(7'h14, 12'h1, 12'h2, 1'b0));
    finishCompute("R8 clears");
    xfer(0, 32'h0000_0003, 0);
    check("R12 row3 intact", busRdata, 32'hCAFE_F00D);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_plain();
    t_twoop();
    t_multi();
    t_badpat();
    t_unknown();
    t_illread();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule